// File: doc/BRIEF.md
# AEGIS-128 State Core

This block keeps the 640-bit AEGIS-128 cipher state as five 128-bit words and advances it. Each advance XORs every word with a keyless AES round of its ring predecessor, and a 128-bit message word enters word 0 only. A message advance is requested over a valid/ready stream input. An advance is taken on a rising clock edge where `upd_valid` and `upd_ready` are both high, and one advance completes per cycle. When `upd_ready` is low the sender must hold `upd_msg` and keep `upd_valid` asserted. Nothing is consumed in that cycle.

A one-cycle `init_start` pulse loads the state from a key and an IV and mixes in fixed constants. It then runs ten advances on its own. During those ten cycles `upd_ready` stays low and `busy` is high. `done` pulses when the sequence ends. The five state words are visible on the outputs at all times, so downstream keystream, tag and buffering logic can read them directly.

Top module: `aegis_state_core`

## Requirements
- R1: While `rst` is high at a clock edge, all five state words clear to zero, `busy` and `done` go low, and `upd_ready` is high afterwards when `init_start` is low.
- R2: An advance sets S1 to S1^R(S0), S2 to S2^R(S1), S3 to S3^R(S2) and S4 to S4^R(S3). Every term uses the state from before the edge.
- R3: An advance sets S0 to S0^R(S4)^M, where M is the message word of that advance.
- R4: R is one AES round with an all-zero round key: ShiftRows, then SubBytes, then MixColumns. Byte i of a word sits in bits [8i+7:8i]. ShiftRows makes output byte i equal to input byte (i+4*(i mod 4)) mod 16. Column c holds bytes 4c..4c+3. As a result, R of the all-zero word is 0x63 in every byte.
- R5: A message advance happens only on an edge with `upd_valid` and `upd_ready` both high. While idle with `upd_valid` low, the state does not change.
- R6: On the edge that accepts `init_start` (when `busy` is low), the state loads S0=K^IV, S1=C1, S2=C0, S3=K^C0 and S4=K^C1. C0 and C1 hold the Fibonacci numbers mod 256 with byte 0 being the first: C0 takes terms 0..15 (00 01 01 02 ... 79 62) and C1 takes terms 16..31 (db 3d ...).
- R7: After the load, ten advances run on consecutive edges. Their messages alternate K, K^IV, K, ... with K first. K and IV are the values sampled at the load edge.
- R8: `busy` and the low `upd_ready` last exactly ten cycles after the load. `done` is high for one cycle, in the cycle right after the tenth advance.
- R9: `init_start` while `busy` is ignored. `upd_valid` is not served while `busy`. When `init_start` and `upd_valid` are high together while idle, `upd_ready` is low and only the load takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key | input | 128 | Key K, sampled at the load edge |
| iv | input | 128 | Initialization vector, sampled at the load edge |
| init_start | input | 1 | Request to run the initialization |
| upd_valid | input | 1 | Message word is offered |
| upd_ready | output | 1 | Message word is accepted at the edge |
| upd_msg | input | 128 | Message word M |
| st0 | output | 128 | State word S0 |
| st1 | output | 128 | State word S1 |
| st2 | output | 128 | State word S2 |
| st3 | output | 128 | State word S3 |
| st4 | output | 128 | State word S4 |
| busy | output | 1 | Initialization in progress |
| done | output | 1 | One-cycle pulse at the end of initialization |

## Verification
The bench builds the block with its default of five key/key^IV pairs, so the full ten-step initialization is exercised cycle by cycle. It runs a chain of 256 message advances in which the message bytes sweep every value 0..255. Because the state carries forward, every S-box input occurs many times across the five rounds. The expected state comes from an independent model, in which the S-box is generated from the field generator 3 and the constants from a Fibonacci recurrence.

// File: rtl/aegis_pkg.sv
package aegis_pkg;

  localparam int WORD_W  = 128;
  localparam int NWORDS  = 5;
  localparam int NBYTES  = WORD_W / 8;

  typedef logic [WORD_W-1:0] word_t;

  // Fibonacci-derived constants, byte 0 in bits [7:0]
  localparam word_t CONST_A = 128'h6279e990_59372215_0d080503_02010100;
  localparam word_t CONST_B = 128'hdd28b573_42311120_f12fc26d_55183ddb;

  function automatic logic [7:0] xtime(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254 (zero maps to zero)
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h01;
    p   = x;
    for (int i = 0; i < 7; i++) begin
      p   = gf_mul(p, p);
      acc = gf_mul(acc, p);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int k);
    return (v << k) | (v >> (8 - k));
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

endpackage

// File: rtl/aegis_aes_round.sv
module aegis_aes_round
  import aegis_pkg::*;
(
  input  word_t din,
  output word_t dout
);

  logic [7:0] sb [NBYTES];

  // shift rows folded into the byte select, then substitution
  for (genvar i = 0; i < NBYTES; i++) begin : g_sub
    localparam int SRC = (i + 4 * (i % 4)) % 16;
    assign sb[i] = sub_byte(din[8*SRC +: 8]);
  end

  // mix columns: out_r = a_r ^ t ^ xtime(a_r ^ a_{r+1})
  for (genvar c = 0; c < NBYTES / 4; c++) begin : g_col
    logic [7:0] tsum;
    assign tsum = sb[4*c] ^ sb[4*c+1] ^ sb[4*c+2] ^ sb[4*c+3];
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign dout[8*(4*c+r) +: 8] =
        sb[4*c+r] ^ tsum ^ xtime(sb[4*c+r] ^ sb[4*c+(r+1)%4]);
    end
  end

endmodule

// File: rtl/aegis_update_step.sv
module aegis_update_step
  import aegis_pkg::*;
(
  input  word_t cur [NWORDS],
  input  word_t msg,
  output word_t nxt [NWORDS]
);

  word_t rnd [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_rnd
    aegis_aes_round u_round (
      .din  (cur[w]),
      .dout (rnd[w])
    );
  end

  assign nxt[0] = cur[0] ^ rnd[NWORDS-1] ^ msg;
  for (genvar w = 1; w < NWORDS; w++) begin : g_ring
    assign nxt[w] = cur[w] ^ rnd[w-1];
  end

endmodule

// File: rtl/aegis_init_seq.sv
module aegis_init_seq #(
  parameter int PAIRS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  output logic load,
  output logic busy,
  output logic done,
  output logic odd_step
);

  localparam int STEPS = 2 * PAIRS;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [CNT_W-1:0] cnt;

  assign load     = start_req && !busy;
  assign odd_step = cnt[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == CNT_W'(STEPS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CNT_W'(STEPS))); // R7
  AST_BUSY_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cnt == '0)); // R8

endmodule

// File: rtl/aegis_state_core.sv
module aegis_state_core
  import aegis_pkg::*;
#(
  parameter int PAIRS = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [127:0] key,
  input  logic [127:0] iv,
  input  logic         init_start,
  input  logic         upd_valid,
  output logic         upd_ready,
  input  logic [127:0] upd_msg,
  output logic [127:0] st0,
  output logic [127:0] st1,
  output logic [127:0] st2,
  output logic [127:0] st3,
  output logic [127:0] st4,
  output logic         busy,
  output logic         done
);

  word_t s   [NWORDS];
  word_t nxt [NWORDS];
  word_t key_q;
  word_t kiv_q;
  word_t step_msg;
  logic  load;
  logic  odd_step;
  logic  fire;

  aegis_init_seq #(.PAIRS(PAIRS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (init_start),
    .load      (load),
    .busy      (busy),
    .done      (done),
    .odd_step  (odd_step)
  );

  assign upd_ready = !busy && !init_start;
  assign fire      = upd_valid && upd_ready;
  assign step_msg  = busy ? (odd_step ? kiv_q : key_q) : upd_msg;

  aegis_update_step u_step (
    .cur (s),
    .msg (step_msg),
    .nxt (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NWORDS; w++) s[w] <= '0;
      key_q <= '0;
      kiv_q <= '0;
    end else if (load) begin
      key_q <= key;
      kiv_q <= key ^ iv;
      s[0]  <= key ^ iv;
      s[1]  <= CONST_B;
      s[2]  <= CONST_A;
      s[3]  <= key ^ CONST_A;
      s[4]  <= key ^ CONST_B;
    end else if (busy || fire) begin
      for (int w = 0; w < NWORDS; w++) s[w] <= nxt[w];
    end
  end

  assign st0 = s[0];
  assign st1 = s[1];
  assign st2 = s[2];
  assign st3 = s[3];
  assign st4 = s[4];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !init_start && !upd_valid) |=>
      ($stable(st0) && $stable(st1) && $stable(st2) && $stable(st3) && $stable(st4))); // R5
  AST_LOAD_CONST: assert property (@(posedge clk) disable iff (rst)
    (init_start && !busy) |=> (st1 == CONST_B && st2 == CONST_A && busy)); // R6
  AST_LOAD_KIV: assert property (@(posedge clk) disable iff (rst)
    (init_start && !busy) |=> (st0 == ($past(key) ^ $past(iv)))); // R6
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !upd_ready); // R9

endmodule

// File: tb/aegis_state_core_tb.sv
module aegis_state_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int SR [16] = '{0, 5, 10, 15, 4, 9, 14, 3, 8, 13, 2, 7, 12, 1, 6, 11};

  logic         clk = 1'b0;
  logic         rst;
  logic [127:0] key, iv, upd_msg;
  logic         init_start, upd_valid;
  logic         upd_ready, busy, done;
  logic [127:0] st0, st1, st2, st3, st4;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic finished = 1'b0;

  logic [7:0]   sb [256];
  logic [127:0] ms [5];
  logic [127:0] c0, c1;

  always #(CLK_PERIOD/2) clk = ~clk;

  aegis_state_core u_dut (
    .clk(clk), .rst(rst), .key(key), .iv(iv), .init_start(init_start),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_msg(upd_msg),
    .st0(st0), .st1(st1), .st2(st2), .st3(st3), .st4(st4),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] dbl(input logic [7:0] v);
    return (v << 1) ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [127:0] rnd(input logic [127:0] w);
    logic [7:0] a [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) a[i] = sb[w[8*SR[i] +: 8]];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[8*(4*c+r) +: 8] = dbl(a[4*c+r]) ^ dbl(a[4*c+(r+1)%4]) ^ a[4*c+(r+1)%4]
                          ^ a[4*c+(r+2)%4] ^ a[4*c+(r+3)%4];
    return o;
  endfunction

  task automatic m_update(input logic [127:0] m);
    logic [127:0] o [5];
    o[0] = ms[0] ^ rnd(ms[4]) ^ m;
    for (int w = 1; w < 5; w++) o[w] = ms[w] ^ rnd(ms[w-1]);
    for (int w = 0; w < 5; w++) ms[w] = o[w];
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " S0"}, st0, ms[0]);
    chk({req, " S1"}, st1, ms[1]);
    chk({req, " S2"}, st2, ms[2]);
    chk({req, " S3"}, st3, ms[3]);
    chk({req, " S4"}, st4, ms[4]);
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic run_init(input logic [127:0] k, input logic [127:0] v);
    logic [127:0] kiv;
    kiv = k ^ v;
    key = k; iv = v; init_start = 1'b1; upd_valid = 1'b1; upd_msg = ~k;
    tick();
    ms[0] = kiv; ms[1] = c1; ms[2] = c0; ms[3] = k ^ c0; ms[4] = k ^ c1;
    chk_state("R6 load");
    chk("R9 ready low at load", {127'd0, upd_ready}, 128'd0);
    chk("R8 busy after load", {127'd0, busy}, 128'd1);
    init_start = 1'b0;
    key = ~k; iv = ~v;
    for (int step = 1; step <= 10; step++) begin
      if (step == 3) init_start = 1'b1;
      if (step == 4) init_start = 1'b0;
      tick();
      m_update((step % 2 == 1) ? k : kiv);
      if (step < 10) begin
        chk("R8 busy during init", {127'd0, busy}, 128'd1);
        chk("R8 done low during init", {127'd0, done}, 128'd0);
        chk("R9 ready low during init", {127'd0, upd_ready}, 128'd0);
      end
    end
    upd_valid = 1'b0;
    chk("R8 done pulse", {127'd0, done}, 128'd1);
    chk("R8 busy released", {127'd0, busy}, 128'd0);
    chk_state("R7 init result");
    tick();
    chk("R8 done one cycle", {127'd0, done}, 128'd0);
    chk_state("R5 hold after init");
  endtask

  initial begin
    logic [7:0] p, q;
    logic [7:0] f [32];
    p = 8'h01; q = 8'h01;
    sb[0] = 8'h63;
    for (int n = 0; n < 255; n++) begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ ((q << 1) | (q >> 7)) ^ ((q << 2) | (q >> 6))
            ^ ((q << 3) | (q >> 5)) ^ ((q << 4) | (q >> 4)) ^ 8'h63;
    end
    f[0] = 8'h00; f[1] = 8'h01;
    for (int n = 2; n < 32; n++) f[n] = f[n-1] + f[n-2];
    for (int n = 0; n < 16; n++) begin
      c0[8*n +: 8] = f[n];
      c1[8*n +: 8] = f[n+16];
    end

    rst = 1'b1; key = '0; iv = '0; init_start = 1'b0; upd_valid = 1'b0; upd_msg = '0;
    for (int w = 0; w < 5; w++) ms[w] = '0;
    repeat (3) tick();
    rst = 1'b0;
    #1;
    chk_state("R1 reset state");
    chk("R1 busy", {127'd0, busy}, 128'd0);
    chk("R1 done", {127'd0, done}, 128'd0);
    chk("R1 ready", {127'd0, upd_ready}, 128'd1);

    // idle hold with valid low
    upd_msg = {16{8'ha5}};
    repeat (3) tick();
    chk_state("R5 idle hold");

    // known answer from zero state
    upd_valid = 1'b1; upd_msg = '0;
    tick();
    upd_valid = 1'b0;
    chk("R4 known answer S1", st1, {16{8'h63}});
    chk("R3 known answer S0", st0, {16{8'h63}});
    m_update('0);
    chk_state("R2 first update");

    // sweep of message byte values with gaps
    for (int v = 0; v < 256; v++) begin
      logic [127:0] m;
      for (int b = 0; b < 16; b++) m[8*b +: 8] = 8'(v) ^ 8'(b * 29);
      upd_msg = m; upd_valid = 1'b1;
      tick();
      m_update(m);
      chk_state("R2 R3 R4 sweep");
      if (v % 16 == 5) begin
        upd_valid = 1'b0; upd_msg = ~m;
        tick();
        chk_state("R5 gap hold");
      end
    end
    upd_valid = 1'b0;

    run_init(128'h000102030405060708090a0b0c0d0e0f, 128'h101112131415161718191a1b1c1d1e1f);
    upd_valid = 1'b1; upd_msg = 128'hdeadbeef_00112233_44556677_8899aabb;
    tick();
    upd_valid = 1'b0;
    m_update(128'hdeadbeef_00112233_44556677_8899aabb);
    chk_state("R5 update after init");

    run_init('0, '0);
    run_init({4{32'hf0e1d2c3}}, {4{32'h3c2d1e0f}});

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG && !finished) begin
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

endmodule